// File: doc/BRIEF.md
# Southbound Command Pattern Matcher

This block observes decoded southbound memory-channel frames, one frame per cycle in which the frame-valid strobe is high. A frame is 120 bits wide and holds three 40-bit command slots, A, B and C. Three command patterns are loaded into the block, each with its own 40-bit compare value and 40-bit mask. A slot hits a pattern when every bit selected by the mask equals the compare value.

Three event outputs are formed from these hits. Each event has a configuration word with up to three conditions. Each condition names one pattern and one slot, or "any slot". An event pulses when it has at least one enabled condition and every enabled condition is met by the same frame. When the frame-type bit shows a command-plus-write-data frame, only slot A carries a command, so slots B and C never produce a hit. A trace-capture or trigger unit uses the pulses to qualify storage or to start a capture.

Top module: `sb_cmd_matcher`

## Requirements
- R1: While `rst` is high and in the cycle after it, `evt_o` is 0. Reset clears all compare values and masks to 0 and disables all event conditions.
- R2: A write with `cfg_we` high takes effect at the clock edge that samples it. Address 2p (p = 0..2) loads the compare value of pattern p, and address 2p+1 loads its mask. Addresses 8, 9 and 10 load the configuration words of events 0, 1 and 2 from `cfg_wdata[14:0]`. A frame presented in the same cycle as a write is judged against the values held before that write.
- R3: A slot hits pattern p when ((slot XOR compare) AND mask) is zero. A mask bit of 1 means the bit is compared, and a mask bit of 0 means it is ignored.
- R4: Slot A is `frm_data[39:0]`, slot B is `frm_data[79:40]` and slot C is `frm_data[119:80]`.
- R5: Condition c (c = 0..2) of an event word sits at bits [5c+4:5c]. Bit 5c+4 enables it. Bits [5c+3:5c+2] give the pattern index, and index 3 is never met. Bits [5c+1:5c] select the slot: 0 for A, 1 for B, 2 for C, 3 for any slot.
- R6: An event fires for a frame when at least one of its conditions is enabled and all of its enabled conditions are met by that frame. Disabled conditions are ignored.
- R7: An event whose three enable bits are all 0 never fires, whatever the frame holds.
- R8: When `frm_data[25]` (frame-type bit 25 in slot A) is 1, the frame is a write-data frame. Slots B and C then never hit, while slot A is still compared.
- R9: `evt_o` bit e is high for exactly the one cycle after the edge that sampled a qualifying frame. It is 0 after any edge at which `frm_valid` was low.
- R10: A write to any address other than 0 to 5 and 8 to 10 changes no stored value, which is seen through the events raised by later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_valid | input | 1 | Frame strobe, one frame per high cycle |
| frm_data | input | 120 | Frame holding slots A, B and C |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 40 | Configuration write data |
| evt_o | output | 3 | Event pulses, one bit per event |

## Verification
A configuration write and a frame comparison can fall on the same clock edge. The bench provokes this by issuing writes to compare values, masks and event words while a frame is valid, including frames built to hit the pattern being rewritten. The bench judges each such cycle against a model that applies the write only after it has predicted that frame's events. A design that lets the new value reach the comparators early therefore disagrees on the pulse.

// File: rtl/sb_cmd_matcher.sv
module sb_cmd_matcher #(
  parameter int SLOT_W   = 40,
  parameter int N_PAT    = 3,
  parameter int N_EVT    = 3,
  parameter int TYPE_BIT = 25,
  parameter int ADDR_W   = 4,
  parameter int EV_BASE  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frm_valid,
  input  logic [3*SLOT_W-1:0]   frm_data,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [SLOT_W-1:0]     cfg_wdata,
  output logic [N_EVT-1:0]      evt_o
);
  localparam int N_SLOT = 3;
  localparam int N_COND = 3;
  localparam int COND_W = 5;
  localparam int EV_W   = N_COND * COND_W;
  localparam int PI_N   = 4;

  logic [SLOT_W-1:0] pat_match [N_PAT];
  logic [SLOT_W-1:0] pat_mask  [N_PAT];
  logic [EV_W-1:0]   evt_cfg   [N_EVT];
  logic [PI_N-1:0][N_SLOT-1:0] hit;
  logic [N_EVT-1:0]  evt_nxt;

  wire wr_frame = frm_data[TYPE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < N_PAT; p++) begin
        pat_match[p] <= '0;
        pat_mask[p]  <= '0;
      end
      for (int e = 0; e < N_EVT; e++) evt_cfg[e] <= '0;
    end else if (cfg_we) begin
      for (int p = 0; p < N_PAT; p++) begin
        if (cfg_addr == ADDR_W'(2*p))   pat_match[p] <= cfg_wdata;
        if (cfg_addr == ADDR_W'(2*p+1)) pat_mask[p]  <= cfg_wdata;
      end
      for (int e = 0; e < N_EVT; e++)
        if (cfg_addr == ADDR_W'(EV_BASE+e)) evt_cfg[e] <= cfg_wdata[EV_W-1:0];
    end
  end

  for (genvar p = 0; p < PI_N; p++) begin : g_pat
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      if (p < N_PAT) begin : g_live
        assign hit[p][s] = (((frm_data[s*SLOT_W +: SLOT_W] ^ pat_match[p]) & pat_mask[p]) == '0)
                           && (s == 0 || !wr_frame);
      end else begin : g_none
        assign hit[p][s] = 1'b0;
      end
    end
  end

  for (genvar e = 0; e < N_EVT; e++) begin : g_evt
    always_comb begin
      logic             any_en, all_ok, met;
      logic [COND_W-1:0] cond;
      logic [3:0]        sel;
      any_en = 1'b0;
      all_ok = 1'b1;
      for (int c = 0; c < N_COND; c++) begin
        cond = evt_cfg[e][c*COND_W +: COND_W];
        sel  = {1'b0, hit[cond[3:2]]};
        met  = (cond[1:0] == 2'd3) ? |sel : sel[cond[1:0]];
        if (cond[4]) begin
          any_en = 1'b1;
          all_ok = all_ok & met;
        end
      end
      evt_nxt[e] = frm_valid & any_en & all_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) evt_o <= '0;
    else     evt_o <= evt_nxt;
  end
endmodule

// File: rtl/sb_cmd_matcher_chk.sv
module sb_cmd_matcher_chk #(
  parameter int SLOT_W = 40,
  parameter int N_PAT  = 3,
  parameter int N_EVT  = 3,
  parameter int ADDR_W = 4,
  parameter int EV_W   = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_valid,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [SLOT_W-1:0] cfg_wdata,
  input logic [N_EVT-1:0]  evt_o,
  input logic [SLOT_W-1:0] pat_match [N_PAT],
  input logic [SLOT_W-1:0] pat_mask  [N_PAT],
  input logic [EV_W-1:0]   evt_cfg   [N_EVT]
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (evt_o == '0));

  a_r9_evt_needs_frame: assert property (@(posedge clk) disable iff (rst)
    (evt_o != '0) |-> $past(frm_valid));

  for (genvar p = 0; p < N_PAT; p++) begin : g_pw
    a_r2_match_write: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_addr == ADDR_W'(2*p)) |=> (pat_match[p] == $past(cfg_wdata)));
    a_r2_mask_write: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_addr == ADDR_W'(2*p+1)) |=> (pat_mask[p] == $past(cfg_wdata)));
  end

  for (genvar e = 0; e < N_EVT; e++) begin : g_ev
    wire en_any = evt_cfg[e][4] | evt_cfg[e][9] | evt_cfg[e][14];
    a_r7_empty_event_silent: assert property (@(posedge clk) disable iff (rst)
      evt_o[e] |-> $past(en_any));
  end
endmodule

bind sb_cmd_matcher sb_cmd_matcher_chk #(
  .SLOT_W(SLOT_W), .N_PAT(N_PAT), .N_EVT(N_EVT), .ADDR_W(ADDR_W), .EV_W(EV_W)
) u_chk (
  .clk(clk), .rst(rst), .frm_valid(frm_valid), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .evt_o(evt_o),
  .pat_match(pat_match), .pat_mask(pat_mask), .evt_cfg(evt_cfg)
);

// File: tb/sb_cmd_matcher_bench.sv
`timescale 1ns/1ps
module sb_cmd_matcher_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         frm_valid;
  logic [119:0] frm_data;
  logic         cfg_we;
  logic [3:0]   cfg_addr;
  logic [39:0]  cfg_wdata;
  logic [2:0]   evt_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [39:0] mm [3];
  logic [39:0] mk [3];
  logic [14:0] ev [3];

  always #10 clk = ~clk;

  sb_cmd_matcher u_sb_cmd_matcher (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_data(frm_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .evt_o(evt_o)
  );

  function automatic logic [2:0] ref_evt(input logic [119:0] f);
    logic [2:0] r;
    for (int e = 0; e < 3; e++) begin
      bit any = 0, ok = 1;
      for (int c = 0; c < 3; c++) begin
        logic [4:0] w = ev[e][c*5 +: 5];
        bit met = 0;
        if (w[4]) begin
          any = 1;
          if (w[3:2] != 2'd3)
            for (int s = 0; s < 3; s++)
              if ((s == 0 || !f[25]) && (w[1:0] == 2'd3 || int'(w[1:0]) == s) &&
                  (((f[s*40 +: 40] ^ mm[w[3:2]]) & mk[w[3:2]]) == 40'd0))
                met = 1;
          ok = ok & met;
        end
      end
      r[e] = any & ok;
    end
    return r;
  endfunction

  function automatic void model_write(input logic [3:0] a, input logic [39:0] d);
    case (a)
      4'd0, 4'd2, 4'd4: mm[a/2] = d;
      4'd1, 4'd3, 4'd5: mk[a/2] = d;
      4'd8, 4'd9, 4'd10: ev[a-8] = d[14:0];
      default: ;
    endcase
  endfunction

  function automatic logic [39:0] rnd40();
    return {$urandom, $urandom};
  endfunction

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: evt_o=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [3:0] a, input logic [39:0] d,
                      input bit fv, input logic [119:0] f, input string tag);
    logic [2:0] exp;
    cfg_we = we; cfg_addr = a; cfg_wdata = d; frm_valid = fv; frm_data = f;
    exp = fv ? ref_evt(f) : 3'b000;
    @(posedge clk); #2;
    check(evt_o, exp, tag);
    if (we) model_write(a, d);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [39:0] d);
    step(1'b1, a, d, 1'b0, '0, "R2 write idle");
  endtask

  task automatic frm(input logic [119:0] f, input string tag);
    step(1'b0, 4'd0, '0, 1'b1, f, tag);
  endtask

  function automatic logic [39:0] near(input int p);
    logic [39:0] s = (mm[p] & mk[p]) | (rnd40() & ~mk[p]);
    if ($urandom_range(3) == 0) s ^= 40'd1 << $urandom_range(39);
    return s;
  endfunction

  localparam logic [39:0] PV = 40'h12_3456_789A;

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) begin mm[i] = '0; mk[i] = '0; ev[i] = '0; end
    rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; frm_valid = 0; frm_data = 0;
    repeat (3) @(negedge clk);
    check(evt_o, 3'b000, "R1 during reset");
    rst = 1'b0;
    // R1 R7: cleared config, all events disabled, frame never fires
    frm({PV, PV, PV}, "R1 R7 cleared config");

    // R3 R4 R6: pattern 0 full mask, event0 = p0 in slot B
    wr(4'd0, PV); wr(4'd1, {40{1'b1}});
    wr(4'd8, 40'b1_00_01);
    frm({40'd0, PV, 40'd0}, "R6 p0 in slot B fires");
    frm({40'd0, 40'd0, PV}, "R4 p0 in slot A only, event wants B");
    frm({40'd0, PV ^ 40'h1, 40'd0}, "R3 one compared bit differs");
    // R3: mask clears bit 0, so that bit is ignored
    wr(4'd1, {{39{1'b1}}, 1'b0});
    frm({40'd0, PV ^ 40'h1, 40'd0}, "R3 masked bit ignored");
    // R9: idle after a hit
    step(1'b0, 4'd0, '0, 1'b0, {40'd0, PV, 40'd0}, "R9 no strobe no event");

    // R8: write-data frame, bit 25 set; mask out bit 25 in pattern 0
    wr(4'd1, ~(40'd1 << 25));
    wr(4'd9, 40'b1_00_11);
    frm({40'd0, PV, PV | (40'd1 << 25)}, "R8 write-data frame: A any hit, B suppressed");
    frm({PV, PV, 40'd1 << 25}, "R8 write-data frame: B and C never hit");

    // R5: pattern index 3 never met; event2 with p3 any + p0 any
    wr(4'd10, 40'b1_11_11_1_00_11);
    frm({PV, PV, PV}, "R5 index 3 blocks event");
    // R7: disable all conditions of event2 while other bits set
    wr(4'd10, 40'b0_00_11_0_00_11_0_00_11);
    frm({PV, PV, PV}, "R7 no enabled condition");

    // R2: same-cycle write and frame, old values used
    step(1'b1, 4'd0, 40'hAA_AAAA_AAAA, 1'b1, {40'd0, PV, 40'd0}, "R2 write and frame same cycle");
    frm({40'd0, PV, 40'd0}, "R2 new compare value in force");
    step(1'b1, 4'd8, 40'd0, 1'b1, {40'd0, 40'hAA_AAAA_AAAA, 40'd0}, "R2 event word write same cycle");

    // R10: unmapped addresses leave the state intact
    wr(4'd8, 40'b1_00_01);
    foreach (mm[i]) ;
    for (int a = 6; a < 16; a++)
      if (a == 6 || a == 7 || a > 10) wr(4'(a), rnd40());
    frm({40'd0, 40'hAA_AAAA_AAAA, 40'd0}, "R10 unmapped writes ignored");

    // random mix, R6 R3 R5 R8 R2 R9
    for (int blk = 0; blk < 12; blk++) begin
      for (int p = 0; p < 3; p++) begin
        wr(4'(2*p), rnd40());
        wr(4'(2*p+1), rnd40() & rnd40() & rnd40());
      end
      for (int e = 0; e < 3; e++) wr(4'(8+e), {25'd0, 15'($urandom)});
      for (int k = 0; k < 40; k++) begin
        logic [119:0] f;
        for (int s = 0; s < 3; s++) f[s*40 +: 40] = near($urandom_range(2));
        if ($urandom_range(3) == 0) f[25] = 1'b1;
        if ($urandom_range(7) == 0)
          step(1'b1, 4'($urandom_range(15)), rnd40(), 1'b1, f, "R2 random write with frame");
        else if ($urandom_range(5) == 0)
          step(1'b0, 4'd0, '0, 1'b0, f, "R9 random idle");
        else
          frm(f, "R6 random frame");
      end
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule